// File: doc/BRIEF.md
# Aliased-View General Register File

This block stores eight 32-bit general-purpose registers and four single-bit condition flags for an integer datapath. Each register can be accessed as a full 32-bit word, as its low 16-bit half, or as a single byte. A 3-bit register number and a 2-bit view code select the access. There is one synchronous write port and two combinational read ports, so a two-operand instruction can fetch both sources in the same cycle it retires a result.

The byte view is aliased. Byte numbers 0 to 3 name the low byte (bits 7:0) of registers 0 to 3. Byte numbers 4 to 7 name the second byte (bits 15:8) of those same four registers, not registers 4 to 7. A narrow write merges into the stored word and leaves every bit it does not address unchanged. Narrow reads return the selected field zero-extended to 32 bits.

The four flags (carry, sign, overflow, zero) sit in a separate small bank. Each flag has its own write enable, so an operation can update some flags and leave the others as they were.

Top module: `gpr_alias_file`

## Requirements
- R1: After reset every register reads as zero through every view, and all four flags are zero.
- R2: With view code 2'b10, a write stores all 32 bits into register wr_idx, and a read returns all 32 bits of register rd_idx.
- R3: With view code 2'b01, a write replaces bits 15:0 of register wr_idx and keeps bits 31:16. A read returns bits 15:0 with bits 31:16 of the result zero.
- R4: With view code 2'b00 and index 0 to 3, the access targets bits 7:0 of register index. A write keeps bits 31:8 of that register.
- R5: With view code 2'b00 and index 4 to 7, the access targets bits 15:8 of register index-4. Such a write keeps the other bits of that register and leaves registers 4 to 7 unchanged.
- R6: A byte read returns the selected byte in bits 7:0 with bits 31:8 zero.
- R7: A read in the same cycle as a write to the same register returns the value from before the write. The new value is visible from the next cycle on.
- R8: The two read ports select and return data independently of each other in the same cycle.
- R9: Flag bit i (0 carry, 1 sign, 2 overflow, 3 zero) takes flag_wdata[i] at a clock edge only when flag_we[i] is 1, and otherwise holds its value.
- R10: With wr_en low, no register changes, whatever the other write inputs carry.
- R11: View code 2'b11 behaves exactly as the word view 2'b10 for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable for the register write port |
| wr_idx | input | 3 | Register or byte number for the write |
| wr_size | input | 2 | Write view: 00 byte, 01 half, 10/11 word |
| wr_data | input | 32 | Write data, right-aligned for narrow views |
| rd0_idx | input | 3 | Register or byte number for read port 0 |
| rd0_size | input | 2 | View code for read port 0 |
| rd0_data | output | 32 | Zero-extended read data, port 0 |
| rd1_idx | input | 3 | Register or byte number for read port 1 |
| rd1_size | input | 2 | View code for read port 1 |
| rd1_data | output | 32 | Zero-extended read data, port 1 |
| flag_we | input | 4 | Per-flag write enables (carry, sign, overflow, zero) |
| flag_wdata | input | 4 | New flag values, same bit order |
| flags_q | output | 4 | Current flag values |

## Verification
The bench focuses on the aliased byte numbers 4 to 7. A design that maps them straight onto registers 4 to 7 would corrupt those registers and leave the second byte of registers 0 to 3 unchanged. Narrow writes are checked against stored words that have all bits set. A merge that clears the rest of the register, or the wrong byte, shows up as lost upper bits. Same-register reads during a write must return the old value, so a bypass path that forwards the new data is caught. Partial flag enables are checked so that a shared enable shows up as a flag that changed when it should have held.

// File: rtl/gpr_alias_pkg.sv
package gpr_alias_pkg;

   // Access view codes seen on the size inputs
   typedef enum logic [1:0] {
      VW_BYTE = 2'b00,
      VW_HALF = 2'b01,
      VW_WORD = 2'b10,
      VW_WIDE = 2'b11   // alias of the word view
   } view_e;

   // Flag bit positions
   localparam int FLAG_CY = 0;
   localparam int FLAG_SG = 1;
   localparam int FLAG_OV = 2;
   localparam int FLAG_ZR = 3;
   localparam int NFLAGS  = 4;

   localparam int BYTE_W = 8;
   localparam int HALF_W = 16;

endpackage

// File: rtl/gpr_view_read.sv
module gpr_view_read
   import gpr_alias_pkg::*;
#(
   parameter int NREG            = 8,
   parameter int REG_W           = 32,
   parameter bit HIGH_BYTE_ALIAS = 1'b1,
   localparam int IDX_W          = $clog2(NREG)
) (
   input  logic [NREG-1:0][REG_W-1:0] bank_i,
   input  logic [IDX_W-1:0]           idx_i,
   input  logic [1:0]                 size_i,
   output logic [REG_W-1:0]           data_o
);

   localparam int HALF_CNT = NREG / 2;

   logic [REG_W-1:0] word_sel;
   logic [BYTE_W-1:0] byte_sel;

   assign word_sel = bank_i[idx_i];

   generate
      if (HIGH_BYTE_ALIAS) begin : g_alias
         logic              upper_half;
         logic [IDX_W-1:0]  base_idx;
         logic [REG_W-1:0]  base_word;
         assign upper_half = (idx_i >= IDX_W'(HALF_CNT));
         assign base_idx   = upper_half ? (idx_i - IDX_W'(HALF_CNT)) : idx_i;
         assign base_word  = bank_i[base_idx];
         assign byte_sel   = upper_half ? base_word[2*BYTE_W-1:BYTE_W]
                                        : base_word[BYTE_W-1:0];
      end else begin : g_flat
         assign byte_sel = word_sel[BYTE_W-1:0];
      end
   endgenerate

   always_comb begin
      case (view_e'(size_i))
         VW_BYTE: data_o = {{(REG_W-BYTE_W){1'b0}}, byte_sel};
         VW_HALF: data_o = {{(REG_W-HALF_W){1'b0}}, word_sel[HALF_W-1:0]};
         default: data_o = word_sel;
      endcase
   end

endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
   import gpr_alias_pkg::*;
#(
   parameter int NREG            = 8,
   parameter int REG_W           = 32,
   parameter bit HIGH_BYTE_ALIAS = 1'b1,
   parameter int SLOT            = 0,
   localparam int IDX_W          = $clog2(NREG)
) (
   input  logic [REG_W-1:0] old_i,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [1:0]       wr_size_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic             hit_o,
   output logic [REG_W-1:0] next_o
);

   localparam int HALF_CNT = NREG / 2;

   logic             hi_byte;
   logic [IDX_W-1:0] tgt_idx;

   generate
      if (HIGH_BYTE_ALIAS) begin : g_alias
         assign hi_byte = (view_e'(wr_size_i) == VW_BYTE) &&
                          (wr_idx_i >= IDX_W'(HALF_CNT));
         assign tgt_idx = hi_byte ? (wr_idx_i - IDX_W'(HALF_CNT)) : wr_idx_i;
      end else begin : g_flat
         assign hi_byte = 1'b0;
         assign tgt_idx = wr_idx_i;
      end
   endgenerate

   assign hit_o = wr_en_i && (tgt_idx == IDX_W'(SLOT));

   always_comb begin
      next_o = old_i;
      case (view_e'(wr_size_i))
         VW_BYTE: begin
            if (hi_byte) next_o[2*BYTE_W-1:BYTE_W] = wr_data_i[BYTE_W-1:0];
            else         next_o[BYTE_W-1:0]        = wr_data_i[BYTE_W-1:0];
         end
         VW_HALF: next_o[HALF_W-1:0] = wr_data_i[HALF_W-1:0];
         default: next_o = wr_data_i;
      endcase
   end

endmodule

// File: rtl/gpr_flag_bank.sv
module gpr_flag_bank
   import gpr_alias_pkg::*;
#(
   parameter int NF = NFLAGS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] we_i,
   input  logic [NF-1:0] wdata_i,
   output logic [NF-1:0] q_o
);

   for (genvar f = 0; f < NF; f++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q_o[f] <= 1'b0;
         else if (we_i[f]) q_o[f] <= wdata_i[f];
      end

      // R9: a flag without its enable holds
      p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !we_i[f] |=> $stable(q_o[f]));
      // R9: an enabled flag takes the written value
      p_flag_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
         we_i[f] |=> (q_o[f] == $past(wdata_i[f])));
   end

endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file
   import gpr_alias_pkg::*;
#(
   parameter int NREG            = 8,
   parameter int REG_W           = 32,
   parameter bit HIGH_BYTE_ALIAS = 1'b1,
   localparam int IDX_W          = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [1:0]         wr_size,
   input  logic [REG_W-1:0]   wr_data,
   input  logic [IDX_W-1:0]   rd0_idx,
   input  logic [1:0]         rd0_size,
   output logic [REG_W-1:0]   rd0_data,
   input  logic [IDX_W-1:0]   rd1_idx,
   input  logic [1:0]         rd1_size,
   output logic [REG_W-1:0]   rd1_data,
   input  logic [NFLAGS-1:0]  flag_we,
   input  logic [NFLAGS-1:0]  flag_wdata,
   output logic [NFLAGS-1:0]  flags_q
);

   localparam int HALF_CNT = NREG / 2;
   localparam int NRDPORT  = 2;

   if (REG_W < HALF_W) begin : g_chk_w
      $error("REG_W must hold at least the half view");
   end
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_chk_n
      $error("NREG must be a power of two, at least 2");
   end

   logic [NREG-1:0][REG_W-1:0] bank_q;

   // Register slots with per-slot merge logic
   for (genvar r = 0; r < NREG; r++) begin : g_slot
      logic             hit;
      logic [REG_W-1:0] nxt;

      gpr_write_merge #(
         .NREG(NREG), .REG_W(REG_W),
         .HIGH_BYTE_ALIAS(HIGH_BYTE_ALIAS), .SLOT(r)
      ) u_merge (
         .old_i    (bank_q[r]),
         .wr_en_i  (wr_en),
         .wr_idx_i (wr_idx),
         .wr_size_i(wr_size),
         .wr_data_i(wr_data),
         .hit_o    (hit),
         .next_o   (nxt)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   bank_q[r] <= '0;
         else if (hit) bank_q[r] <= nxt;
      end
   end

   // Read ports
   logic [NRDPORT-1:0][IDX_W-1:0] rp_idx;
   logic [NRDPORT-1:0][1:0]       rp_size;
   logic [NRDPORT-1:0][REG_W-1:0] rp_data;

   assign rp_idx  = {rd1_idx, rd0_idx};
   assign rp_size = {rd1_size, rd0_size};

   for (genvar p = 0; p < NRDPORT; p++) begin : g_rport
      gpr_view_read #(
         .NREG(NREG), .REG_W(REG_W), .HIGH_BYTE_ALIAS(HIGH_BYTE_ALIAS)
      ) u_rd (
         .bank_i(bank_q),
         .idx_i (rp_idx[p]),
         .size_i(rp_size[p]),
         .data_o(rp_data[p])
      );

      // R6: byte reads zero-extend
      p_byte_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (view_e'(rp_size[p]) == VW_BYTE) |-> (rp_data[p][REG_W-1:BYTE_W] == '0));
      // R3: half reads zero-extend
      p_half_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (view_e'(rp_size[p]) == VW_HALF) |-> (rp_data[p][REG_W-1:HALF_W] == '0));
   end

   assign rd0_data = rp_data[0];
   assign rd1_data = rp_data[1];

   gpr_flag_bank #(.NF(NFLAGS)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (flag_we),
      .wdata_i(flag_wdata),
      .q_o    (flags_q)
   );

   // R10: idle write port leaves the bank alone
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(bank_q));

   // R3: half writes keep the upper bits of the target
   p_half_upper_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && view_e'(wr_size) == VW_HALF) |=>
      (bank_q[$past(wr_idx)][REG_W-1:HALF_W] == $past(bank_q[wr_idx][REG_W-1:HALF_W])));

   // R2: word writes land in full
   p_word_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && view_e'(wr_size) == VW_WORD) |=> (bank_q[$past(wr_idx)] == $past(wr_data)));

   if (HIGH_BYTE_ALIAS) begin : g_alias_chk
      // R4: low-byte writes keep bits above the byte
      p_low_byte_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && view_e'(wr_size) == VW_BYTE && wr_idx < IDX_W'(HALF_CNT)) |=>
         (bank_q[$past(wr_idx)][REG_W-1:BYTE_W] == $past(bank_q[wr_idx][REG_W-1:BYTE_W])));
      // R5: high-byte numbers never touch the upper registers
      p_hi_byte_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && view_e'(wr_size) == VW_BYTE && wr_idx >= IDX_W'(HALF_CNT)) |=>
         (bank_q[$past(wr_idx)] == $past(bank_q[wr_idx])));
   end

endmodule

// File: tb/gpr_alias_file_tb.sv
module gpr_alias_file_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [1:0]  wr_size = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd0_idx = '0, rd1_idx = '0;
   logic [1:0]  rd0_size = '0, rd1_size = '0;
   logic [31:0] rd0_data, rd1_data;
   logic [3:0]  flag_we = '0, flag_wdata = '0;
   logic [3:0]  flags_q;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] mreg [8];
   logic [3:0]  mflag;

   always #5 clk = ~clk;

   gpr_alias_file dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
      .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_data(rd0_data),
      .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_data(rd1_data),
      .flag_we(flag_we), .flag_wdata(flag_wdata), .flags_q(flags_q)
   );

   function automatic logic [31:0] exp_read(input logic [2:0] idx, input logic [1:0] sz);
      logic [31:0] w;
      if (sz == 2'b00) begin
         if (idx[2]) w = {24'h0, mreg[{1'b0, idx[1:0]}][15:8]};
         else        w = {24'h0, mreg[idx][7:0]};
      end else if (sz == 2'b01) begin
         w = {16'h0, mreg[idx][15:0]};
      end else begin
         w = mreg[idx];
      end
      return w;
   endfunction

   function automatic string tag_for(input logic [2:0] idx, input logic [1:0] sz);
      if (sz == 2'b00) return idx[2] ? "R5" : "R4";
      if (sz == 2'b01) return "R3";
      if (sz == 2'b11) return "R11";
      return "R2";
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic model_write();
      logic [2:0] t;
      if (wr_en) begin
         t = (wr_size == 2'b00 && wr_idx[2]) ? {1'b0, wr_idx[1:0]} : wr_idx;
         case (wr_size)
            2'b00: if (wr_idx[2]) mreg[t][15:8] = wr_data[7:0];
                   else           mreg[t][7:0]  = wr_data[7:0];
            2'b01: mreg[t][15:0] = wr_data[15:0];
            default: mreg[t] = wr_data;
         endcase
      end
      for (int f = 0; f < 4; f++) if (flag_we[f]) mflag[f] = flag_wdata[f];
   endtask

   // One cycle: drive at negedge, check reads before the edge, update model after.
   task automatic step(input logic we, input logic [2:0] wi, input logic [1:0] ws,
                       input logic [31:0] wd, input logic [2:0] r0i, input logic [1:0] r0s,
                       input logic [2:0] r1i, input logic [1:0] r1s,
                       input logic [3:0] fwe, input logic [3:0] fwd, input string tag);
      @(negedge clk);
      wr_en = we; wr_idx = wi; wr_size = ws; wr_data = wd;
      rd0_idx = r0i; rd0_size = r0s; rd1_idx = r1i; rd1_size = r1s;
      flag_we = fwe; flag_wdata = fwd;
      #1;
      chk((tag == "") ? tag_for(r0i, r0s) : tag, rd0_data, exp_read(r0i, r0s));
      chk((tag == "") ? tag_for(r1i, r1s) : tag, rd1_data, exp_read(r1i, r1s));
      chk("R9", {28'h0, flags_q}, {28'h0, mflag});
      @(posedge clk);
      model_write();
   endtask

   initial begin
      int unsigned seed;
      seed = 32'd2024;
      void'($urandom(seed));
      for (int i = 0; i < 8; i++) mreg[i] = '0;
      mflag = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: everything zero after reset
      for (int i = 0; i < 8; i++)
         step(1'b0, 3'd0, 2'b10, 32'h0, 3'(i), 2'b10, 3'(i), 2'b00, 4'h0, 4'h0, "R1");

      // R2: word write and readback
      step(1'b1, 3'd2, 2'b10, 32'hFFFF_FFFF, 3'd0, 2'b10, 3'd0, 2'b10, 4'h0, 4'h0, "");
      step(1'b1, 3'd2, 2'b01, 32'hAAAA_BEEF, 3'd2, 2'b10, 3'd2, 2'b10, 4'h0, 4'h0, "R2");
      // R3: half write kept upper bits
      step(1'b0, 3'd0, 2'b10, 32'h0, 3'd2, 2'b10, 3'd2, 2'b01, 4'h0, 4'h0, "R3");
      chk("R3", rd0_data, 32'hFFFF_BEEF);
      // R5: byte number 6 writes bits 15:8 of register 2
      step(1'b1, 3'd6, 2'b00, 32'h1234_565A, 3'd6, 2'b10, 3'd2, 2'b10, 4'h0, 4'h0, "R5");
      step(1'b0, 3'd0, 2'b10, 32'h0, 3'd2, 2'b10, 3'd6, 2'b10, 4'h0, 4'h0, "R5");
      chk("R5", rd0_data, 32'hFFFF_5AEF);
      chk("R5", rd1_data, 32'h0);
      // R4: byte number 2 writes bits 7:0 of register 2
      step(1'b1, 3'd2, 2'b00, 32'hFFFF_FF33, 3'd0, 2'b10, 3'd0, 2'b10, 4'h0, 4'h0, "");
      step(1'b0, 3'd0, 2'b10, 32'h0, 3'd2, 2'b10, 3'd6, 2'b00, 4'h0, 4'h0, "R4");
      chk("R4", rd0_data, 32'hFFFF_5A33);
      chk("R6", rd1_data, 32'h0000_005A);
      // R11: size code 11 is a word write
      step(1'b1, 3'd7, 2'b11, 32'hCAFE_F00D, 3'd0, 2'b10, 3'd0, 2'b10, 4'h0, 4'h0, "");
      // R7: same-cycle read of register 7 returns the old value
      step(1'b1, 3'd7, 2'b10, 32'h0000_0001, 3'd7, 2'b11, 3'd7, 2'b10, 4'h0, 4'h0, "R7");
      chk("R7", rd0_data, 32'hCAFE_F00D);
      step(1'b0, 3'd7, 2'b10, 32'hDEAD_DEAD, 3'd7, 2'b10, 3'd2, 2'b01, 4'h0, 4'h0, "R10");
      chk("R7", rd0_data, 32'h0000_0001);
      chk("R8", rd1_data, 32'h0000_5A33);
      step(1'b0, 3'd0, 2'b10, 32'h0, 3'd7, 2'b10, 3'd0, 2'b10, 4'h0, 4'h0, "R10");
      chk("R10", rd0_data, 32'h0000_0001);
      // R9: partial flag enables
      step(1'b0, 3'd0, 2'b10, 32'h0, 3'd0, 2'b10, 3'd0, 2'b10, 4'b0101, 4'b1111, "R9");
      step(1'b0, 3'd0, 2'b10, 32'h0, 3'd0, 2'b10, 3'd0, 2'b10, 4'b1000, 4'b0000, "R9");
      step(1'b0, 3'd0, 2'b10, 32'h0, 3'd0, 2'b10, 3'd0, 2'b10, 4'b0000, 4'b1111, "R9");
      chk("R9", {28'h0, flags_q}, 32'h5);

      // Random mix, all ports, all views
      for (int n = 0; n < 3000; n++) begin
         step(1'($urandom), 3'($urandom), 2'($urandom), $urandom,
              3'($urandom), 2'($urandom), 3'($urandom), 2'($urandom),
              4'($urandom), 4'($urandom), "");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog got=%h exp=%h", 32'h0, 32'h1);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule